// File: doc/BRIEF.md
# Repeated String Move Engine

This engine carries out one string primitive on a byte-addressed memory, either once or as a counted loop. A command gives the primitive, the element width, the loop mode and the pointer direction. It also supplies the starting source and destination pointers, a count, an accumulator and an incoming zero flag. The engine drives a synchronous memory port. A read returns its data on the cycle after the request. When the engine finishes, it holds the final pointers, count, accumulator and zero flag on its result outputs.

The five primitives are store, load, move, compare and scan. Compare and scan set the zero flag, and the two conditional loop modes use that flag to end a loop early. Elements are 1, 2 or 4 bytes. Pointers must be aligned to the element size. Elements are placed little-endian on a 32-bit data bus, with per-byte write enables.

Top module: `strm_engine`

## Requirements
- R1: A command is taken when start_i is high while busy_o is low. busy_o is high from the next cycle up to and including the single cycle in which done_o is high. After that cycle both are low, and the result outputs hold the final values.
- R2: Store (op 0) writes the low 1, 2 or 4 bytes of the accumulator (size code 0, 1, 2) to the destination address. The lowest byte goes to the lowest address, and only the enables of the written bytes are set.
- R3: Load (op 1) reads the element at the source address into the low bytes of the accumulator. The accumulator bytes above the element size keep their values.
- R4: Move (op 2) copies the element at the source address to the destination address.
- R5: Compare (op 3) sets the zero flag to 1 when the source and destination elements are equal, and to 0 otherwise.
- R6: Scan (op 4) sets the zero flag to 1 when the low element-size bytes of the accumulator equal the destination element, and to 0 otherwise.
- R7: With dir_i at 0, each iteration adds the element size in bytes to each pointer the primitive uses. With dir_i at 1, each iteration subtracts it. Store and scan use only the destination pointer, load uses only the source pointer, and move and compare use both.
- R8: Loop mode 0 performs exactly one iteration and leaves the count unchanged.
- R9: Loop mode 1 performs the primitive and decrements the count until the count is zero.
- R10: For compare and scan, loop mode 2 stops after the first iteration that clears the zero flag, and loop mode 3 stops after the first iteration that sets it. In both modes the loop also stops when the count reaches zero. The count is decremented in every iteration, including the last one.
- R11: Loop modes 2 and 3 behave like mode 1 for store, load and move.
- R12: A looping command (mode 1 to 3) given with a count of zero makes no memory access. It ends with done_o on the cycle after start, and every result keeps its start value.
- R13: Store, load and move return the zero flag given with the command.
- R14: A start_i pulse while busy_o is high does not change the running command or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 3 | Primitive: 0 store, 1 load, 2 move, 3 compare, 4 scan |
| size_i | input | 2 | Element size: 0 byte, 1 two bytes, 2 four bytes |
| rep_i | input | 2 | Loop mode: 0 once, 1 counted, 2 while equal, 3 while not equal |
| dir_i | input | 1 | 0 steps pointers up, 1 steps them down |
| src_i | input | AW | Starting source pointer |
| dst_i | input | AW | Starting destination pointer |
| cnt_i | input | CW | Starting count |
| acc_i | input | 32 | Starting accumulator |
| zf_i | input | 1 | Starting zero flag |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | AW | Source pointer result |
| dst_o | output | AW | Destination pointer result |
| cnt_o | output | CW | Count result |
| acc_o | output | 32 | Accumulator result |
| zf_o | output | 1 | Zero flag result |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Byte address of the element |
| mem_be_o | output | 4 | Byte write enables |
| mem_wdata_o | output | 32 | Write data, lane-aligned |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |

## Verification
Two events can land in the same update cycle: the zero-flag test ends a conditional loop, and the count reaches zero. The bench sets this up by writing memory so that the first mismatch, or the first match, falls exactly on the last counted element. It also runs runs where the mismatch comes earlier or never comes. In every case the final count, pointers and flag are compared with a byte-level reference model that decrements before testing. A start pulse is also injected in the middle of a looping move, and the results must still match the original command.

// File: rtl/strm_pkg.sv
package strm_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [2:0] {OP_STORE = 3'd0, OP_LOAD = 3'd1, OP_MOVE = 3'd2,
                            OP_CMP = 3'd3, OP_SCAN = 3'd4} op_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2,
                            SZ_RSVD = 2'd3} size_e;
  typedef enum logic [1:0] {RP_NONE = 2'd0, RP_ALL = 2'd1, RP_EQ = 2'd2,
                            RP_NE = 2'd3} rep_e;
  typedef enum logic [2:0] {ST_IDLE, ST_A, ST_B, ST_C, ST_FIN} st_e;

  function automatic logic [2:0] size_bytes(size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] elem_mask(size_e s);
    case (s)
      SZ_BYTE: return BUS_W'(32'h0000_00ff);
      SZ_WORD: return BUS_W'(32'h0000_ffff);
      default: return {BUS_W{1'b1}};
    endcase
  endfunction

  function automatic logic uses_src(op_e o);
    return (o == OP_LOAD) || (o == OP_MOVE) || (o == OP_CMP);
  endfunction

  function automatic logic uses_dst(op_e o);
    return o != OP_LOAD;
  endfunction

  function automatic logic sets_flag(op_e o);
    return (o == OP_CMP) || (o == OP_SCAN);
  endfunction
endpackage

// File: rtl/strm_pack.sv
// Places an element on its byte lanes for a write.
module strm_pack
  import strm_pkg::*;
(
  input  logic [1:0]           lo_i,
  input  size_e                size_i,
  input  logic [BUS_W-1:0]     elem_i,
  output logic [BUS_BYTES-1:0] be_o,
  output logic [BUS_W-1:0]     data_o
);
  logic [2:0]       nb;
  logic [BUS_W-1:0] elem_m;

  assign nb     = size_bytes(size_i);
  assign elem_m = elem_i & elem_mask(size_i);
  assign data_o = elem_m << {lo_i, 3'b000};

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_be
    assign be_o[g] = (g >= int'(lo_i)) && (g < int'(lo_i) + int'(nb));
  end
endmodule

// File: rtl/strm_unpack.sv
// Pulls an element off its byte lanes after a read.
module strm_unpack
  import strm_pkg::*;
(
  input  logic [1:0]       lo_i,
  input  size_e            size_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] elem_o
);
  assign elem_o = (data_i >> {lo_i, 3'b000}) & elem_mask(size_i);
endmodule

// File: rtl/strm_step.sv
module strm_step
  import strm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  size_e         size_i,
  input  logic          dir_i,
  input  logic          en_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] delta;
  assign delta = AW'(size_bytes(size_i));
  assign ptr_o = !en_i ? ptr_i : (dir_i ? ptr_i - delta : ptr_i + delta);
endmodule

// File: rtl/strm_repeat.sv
// Count update and loop continuation after one iteration.
module strm_repeat
  import strm_pkg::*;
#(
  parameter int CW = 16
) (
  input  rep_e          rep_i,
  input  op_e           op_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          zf_i,
  output logic [CW-1:0] cnt_o,
  output logic          cont_o
);
  logic cond;

  assign cnt_o = (rep_i == RP_NONE) ? cnt_i : cnt_i - CW'(1);

  always_comb begin
    cond = 1'b1;
    if (sets_flag(op_i)) begin
      if (rep_i == RP_EQ) cond = zf_i;
      else if (rep_i == RP_NE) cond = !zf_i;
    end
  end

  assign cont_o = (rep_i != RP_NONE) && (cnt_o != '0) && cond;
endmodule

// File: rtl/strm_engine.sv
module strm_engine
  import strm_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           op_i,
  input  logic [1:0]           size_i,
  input  logic [1:0]           rep_i,
  input  logic                 dir_i,
  input  logic [AW-1:0]        src_i,
  input  logic [AW-1:0]        dst_i,
  input  logic [CW-1:0]        cnt_i,
  input  logic [BUS_W-1:0]     acc_i,
  input  logic                 zf_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [AW-1:0]        src_o,
  output logic [AW-1:0]        dst_o,
  output logic [CW-1:0]        cnt_o,
  output logic [BUS_W-1:0]     acc_o,
  output logic                 zf_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [BUS_BYTES-1:0] mem_be_o,
  output logic [BUS_W-1:0]     mem_wdata_o,
  input  logic [BUS_W-1:0]     mem_rdata_i
);
  st_e              st_q;
  op_e              op_q;
  size_e            size_q;
  rep_e             rep_q;
  logic             dir_q, zf_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CW-1:0]    cnt_q;
  logic [BUS_W-1:0] acc_q, tmp_q;
  logic [1:0]       rd_lo_q;

  logic [BUS_W-1:0] rd_elem, wr_elem, acc_new;
  logic [AW-1:0]    src_nx, dst_nx;
  logic [CW-1:0]    cnt_nx;
  logic             zf_new, cont, iter_end;

  // Memory access sequencing per primitive
  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = dst_q;
    if (st_q == ST_A) begin
      mem_req_o  = 1'b1;
      mem_we_o   = (op_q == OP_STORE);
      mem_addr_o = uses_src(op_q) ? src_q : dst_q;
    end else if (st_q == ST_B && (op_q == OP_MOVE || op_q == OP_CMP)) begin
      mem_req_o = 1'b1;
      mem_we_o  = (op_q == OP_MOVE);
    end
  end

  assign wr_elem = (op_q == OP_MOVE) ? rd_elem : acc_q;

  strm_pack u_pack (
    .lo_i  (mem_addr_o[1:0]),
    .size_i(size_q),
    .elem_i(wr_elem),
    .be_o  (mem_be_o),
    .data_o(mem_wdata_o)
  );

  strm_unpack u_unpack (
    .lo_i  (rd_lo_q),
    .size_i(size_q),
    .data_i(mem_rdata_i),
    .elem_o(rd_elem)
  );

  assign iter_end = (st_q == ST_A && op_q == OP_STORE) ||
                    (st_q == ST_B && (op_q == OP_LOAD || op_q == OP_MOVE || op_q == OP_SCAN)) ||
                    (st_q == ST_C);

  always_comb begin
    zf_new  = zf_q;
    acc_new = acc_q;
    if (st_q == ST_C)
      zf_new = (tmp_q == rd_elem);
    else if (st_q == ST_B && op_q == OP_SCAN)
      zf_new = ((acc_q & elem_mask(size_q)) == rd_elem);
    if (st_q == ST_B && op_q == OP_LOAD)
      acc_new = (acc_q & ~elem_mask(size_q)) | rd_elem;
  end

  strm_step #(.AW(AW)) u_step_src (
    .ptr_i (src_q), .size_i(size_q), .dir_i(dir_q),
    .en_i  (uses_src(op_q)), .ptr_o(src_nx)
  );

  strm_step #(.AW(AW)) u_step_dst (
    .ptr_i (dst_q), .size_i(size_q), .dir_i(dir_q),
    .en_i  (uses_dst(op_q)), .ptr_o(dst_nx)
  );

  strm_repeat #(.CW(CW)) u_repeat (
    .rep_i (rep_q), .op_i(op_q), .cnt_i(cnt_q),
    .zf_i  (zf_new), .cnt_o(cnt_nx), .cont_o(cont)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_STORE;
      size_q  <= SZ_BYTE;
      rep_q   <= RP_NONE;
      dir_q   <= 1'b0;
      zf_q    <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      tmp_q   <= '0;
      rd_lo_q <= '0;
    end else begin
      if (mem_req_o && !mem_we_o) rd_lo_q <= mem_addr_o[1:0];
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q   <= op_e'(op_i);
          size_q <= size_e'(size_i);
          rep_q  <= rep_e'(rep_i);
          dir_q  <= dir_i;
          src_q  <= src_i;
          dst_q  <= dst_i;
          cnt_q  <= cnt_i;
          acc_q  <= acc_i;
          zf_q   <= zf_i;
          st_q   <= (rep_i != 2'd0 && cnt_i == '0) ? ST_FIN : ST_A;
        end
        ST_A: if (!iter_end) st_q <= ST_B;
        ST_B: if (op_q == OP_CMP) begin
          tmp_q <= rd_elem;
          st_q  <= ST_C;
        end
        ST_C: ;
        default: st_q <= ST_IDLE;
      endcase
      if (iter_end) begin
        src_q <= src_nx;
        dst_q <= dst_nx;
        cnt_q <= cnt_nx;
        acc_q <= acc_new;
        zf_q  <= zf_new;
        st_q  <= cont ? ST_A : ST_FIN;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign acc_o  = acc_q;
  assign zf_o   = zf_q;

  p_done_then_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  p_write_lanes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> $countones(mem_be_o) == int'(size_bytes(size_q)));

  p_once_keeps_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rep_q == RP_NONE |=> $stable(cnt_q));

  p_count_never_rises_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> cnt_q <= $past(cnt_q));

  p_zero_count_no_access_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && rep_i != 2'd0 && cnt_i == '0 |=> done_o && !mem_req_o);

  p_flag_kept_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !sets_flag(op_q) |=> $stable(zf_q));

  p_start_ignored_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(op_q) && $stable(rep_q) && $stable(size_q));
endmodule

// File: tb/strm_engine_tb_top.sv
module strm_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0, rep = '0;
  logic        dir = 1'b0, zf_in = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [31:0] acc_in = '0;
  logic        busy, done, zf_out, mreq, mwe;
  logic [15:0] src_out, dst_out, cnt_out, maddr;
  logic [31:0] acc_out, mwdata, mrdata;
  logic [3:0]  mbe;

  int errors = 0;
  int checks = 0;
  int req_seen = 0;

  logic [31:0] mem_w [64];
  logic [7:0]  ref_b [256];

  always #5 clk = ~clk;

  strm_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(size),
    .rep_i(rep), .dir_i(dir), .src_i(src_in), .dst_i(dst_in), .cnt_i(cnt_in),
    .acc_i(acc_in), .zf_i(zf_in), .busy_o(busy), .done_o(done),
    .src_o(src_out), .dst_o(dst_out), .cnt_o(cnt_out), .acc_o(acc_out),
    .zf_o(zf_out), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_be_o(mbe), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  always @(posedge clk) begin
    if (mreq) req_seen <= req_seen + 1;
    if (mreq && mwe) begin
      for (int b = 0; b < 4; b++)
        if (mbe[b]) mem_w[maddr[7:2]][8*b +: 8] <= mwdata[8*b +: 8];
    end else if (mreq) begin
      mrdata <= mem_w[maddr[7:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] v);
    ref_b[a] = v;
    mem_w[a[7:2]][8*a[1:0] +: 8] = v;
  endtask

  function automatic int nbytes(input int sz);
    return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
  endfunction

  // Byte-level reference of one command
  task automatic ref_exec(input int o, input int sz, input int rp, input bit dr,
                          inout logic [15:0] s, inout logic [15:0] d,
                          inout logic [15:0] c, inout logic [31:0] a, inout bit z);
    int nb = nbytes(sz);
    if (rp != 0 && c == 0) return;
    for (int guard = 0; guard < 70000; guard++) begin
      for (int b = 0; b < nb; b++) begin
        logic [7:0] si = 8'(s + 16'(b));
        logic [7:0] di = 8'(d + 16'(b));
        if (b == 0 && (o == 3 || o == 4)) z = 1'b1;
        case (o)
          0: ref_b[di] = a[8*b +: 8];
          1: a[8*b +: 8] = ref_b[si];
          2: ref_b[di] = ref_b[si];
          3: if (ref_b[si] != ref_b[di]) z = 1'b0;
          default: if (a[8*b +: 8] != ref_b[di]) z = 1'b0;
        endcase
      end
      if (o == 1 || o == 2 || o == 3) s = dr ? s - 16'(nb) : s + 16'(nb);
      if (o != 1) d = dr ? d - 16'(nb) : d + 16'(nb);
      if (rp == 0) break;
      c = c - 16'd1;
      if (c == 0) break;
      if (o >= 3 && rp == 2 && !z) break;
      if (o >= 3 && rp == 3 && z) break;
    end
  endtask

  task automatic run_cmd(input string tag, input int o, input int sz, input int rp,
                         input bit dr, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] c, input logic [31:0] a, input bit z,
                         input bit inject);
    logic [15:0] es = s, ed = d, ec = c;
    logic [31:0] ea = a;
    bit ez = z;
    int n;
    int req0;
    ref_exec(o, sz, rp, dr, es, ed, ec, ea, ez);
    @(negedge clk);
    op = 3'(o); size = 2'(sz); rep = 2'(rp); dir = dr;
    src_in = s; dst_in = d; cnt_in = c; acc_in = a; zf_in = z;
    start = 1'b1;
    req0 = req_seen;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", {tag, " busy after start"}, 32'(busy), 32'd1);
    if (inject) begin
      op = 3'd0; rep = 2'd1; cnt_in = 16'd9; dst_in = 16'h00f0; acc_in = 32'hdead_beef;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) begin
      chk(1'b0, "R1", {tag, " watchdog"}, 32'(n), 32'd0);
      return;
    end
    chk(src_out == es, tag, "source pointer", 32'(src_out), 32'(es));
    chk(dst_out == ed, tag, "destination pointer", 32'(dst_out), 32'(ed));
    chk(cnt_out == ec, tag, "count", 32'(cnt_out), 32'(ec));
    chk(acc_out == ea, tag, "accumulator", acc_out, ea);
    chk(zf_out == ez, tag, "zero flag", 32'(zf_out), 32'(ez));
    for (int w = 0; w < 64; w++) begin
      logic [31:0] ew = {ref_b[4*w+3], ref_b[4*w+2], ref_b[4*w+1], ref_b[4*w]};
      if (mem_w[w] != ew) begin
        chk(1'b0, tag, $sformatf("memory word %0d", w), mem_w[w], ew);
        break;
      end
    end
    checks++;
    if (rp != 0 && c == 0)
      chk(req_seen == req0, "R12", {tag, " accesses"}, 32'(req_seen - req0), 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R1", {tag, " done single cycle"}, {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) poke(8'(i), 8'($urandom_range(0, 1)));
    mrdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mreq == 1'b0, "R1", "reset outputs",
        {29'd0, busy, done, mreq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd("R2 store dword", 0, 2, 0, 0, 16'h0000, 16'h0010, 16'd5, 32'h1122_3344, 1'b1, 0);
    chk(mem_w[4] == 32'h1122_3344, "R2", "little-endian word", mem_w[4], 32'h1122_3344);
    run_cmd("R7 R9 store byte down", 0, 0, 1, 1, 16'h0000, 16'h0023, 16'd3, 32'h0000_00a5, 1'b0, 0);
    run_cmd("R3 load word keeps upper", 1, 1, 0, 0, 16'h0032, 16'h0000, 16'd1, 32'hcafe_0000, 1'b0, 0);
    run_cmd("R4 move bytes", 2, 0, 1, 0, 16'h0040, 16'h0080, 16'd5, 32'd0, 1'b1, 0);
    run_cmd("R8 move once", 2, 2, 0, 1, 16'h0044, 16'h0090, 16'd7, 32'd0, 1'b0, 0);

    for (int i = 0; i < 8; i++) begin poke(8'(8'hA0 + i), 8'h33); poke(8'(8'hC0 + i), 8'h33); end
    poke(8'hA5, 8'h34);
    run_cmd("R5 R10 compare while-equal early", 3, 0, 2, 0, 16'h00A0, 16'h00C0, 16'd8, 32'd0, 1'b0, 0);
    poke(8'hA5, 8'h33); poke(8'hA7, 8'h00);
    run_cmd("R10 compare mismatch on last", 3, 0, 2, 0, 16'h00A0, 16'h00C0, 16'd8, 32'd0, 1'b0, 0);
    run_cmd("R5 compare dword down", 3, 2, 1, 1, 16'h00A4, 16'h00C4, 16'd2, 32'd0, 1'b0, 0);

    for (int i = 0; i < 8; i++) poke(8'(8'hD0 + i), 8'h00);
    poke(8'hD6, 8'h5a);
    run_cmd("R6 R10 scan while-not-equal", 4, 1, 3, 0, 16'h0000, 16'h00D0, 16'd4, 32'h0000_005a, 1'b0, 0);
    run_cmd("R6 scan none found", 4, 0, 3, 0, 16'h0000, 16'h00D0, 16'd4, 32'h0000_0077, 1'b1, 0);
    run_cmd("R11 R13 store with while-equal", 0, 0, 2, 0, 16'h0000, 16'h00E0, 16'd4, 32'h0000_0099, 1'b0, 0);
    run_cmd("R11 load with while-not-equal", 1, 0, 3, 0, 16'h00E0, 16'h0000, 16'd3, 32'h1234_5678, 1'b1, 0);
    run_cmd("R12 zero count", 2, 1, 1, 0, 16'h0010, 16'h0050, 16'd0, 32'h0bad_f00d, 1'b1, 0);
    run_cmd("R14 start while busy", 2, 0, 1, 0, 16'h0060, 16'h0070, 16'd4, 32'h0000_0001, 1'b0, 1);

    for (int t = 0; t < 150; t++) begin
      int o  = $urandom_range(0, 4);
      int sz = $urandom_range(0, 2);
      int nb = nbytes(sz);
      logic [15:0] s = 16'($urandom_range(0, 255)) & ~16'(nb - 1);
      logic [15:0] d = 16'($urandom_range(0, 255)) & ~16'(nb - 1);
      logic [31:0] a = $urandom() & 32'h0101_0101;
      run_cmd("random R7 R9 R10", o, sz, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
              s, d, 16'($urandom_range(0, 6)), a, 1'($urandom_range(0, 1)), 0);
    end
    if (seed == 0) $display("seed zero");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL R1 global watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule